// File: doc/BRIEF.md
# One-Wire Search Branch Step

This block carries out a single branch decision of a one-wire ROM search. After a start it asks a bit-slot engine for two read slots. The first returns the true value of the current address bit across all devices still taking part, and the second returns its complement. From those two bits and a requested default direction it picks which branch to follow. It then issues one write slot that carries the chosen bit, so devices on the other branch drop out.

The surrounding search loop feeds it one address position at a time. It reads back a three-bit status after each step and restarts the search when the status reports that no device answered.

The unit does not time the bus itself. Each slot is a request to the bit-slot engine, and the engine answers with an acknowledge pulse, plus the sampled level for a read slot.

Top module: `trip_search_step`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, busy_o, done_o and slot_req_o are 0 and status_o is 000. A reset in the middle of a step returns the unit to this state.
- R2: A step issues exactly two read slots (slot_write_o=0) first, then at most one write slot (slot_write_o=1). Each request stays high with an unchanged kind until the cycle in which slot_ack_i is 1.
- R3: The status field positions are fixed: status_o[0] is the first (true) bit read, status_o[1] is the second (complement) bit read, and status_o[2] is the direction taken.
- R4: If both read bits are 1, status_o is 3'b011 and no write slot is issued.
- R5: If both read bits are 0, the requested direction is written. status_o is 3'b100 when that direction is 1 and 3'b000 when it is 0.
- R6: If exactly one read bit is 1, the true bit is written as the direction. status_o is 3'b101 when the true bit is 1 and 3'b010 when it is 0.
- R7: dir_i is sampled only in the cycle a start is accepted. Later changes to dir_i do not affect the step.
- R8: start_i is ignored while busy_o is 1.
- R9: done_o is a one-cycle pulse in the cycle after the acknowledge of the step's last slot. status_o changes only in a done_o cycle and holds its value until the next one.
- R10: busy_o rises in the cycle after an accepted start. It stays high through the done_o cycle and falls in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin one search step when idle |
| dir_i | input | 1 | Requested direction when both read bits are 0 |
| busy_o | output | 1 | Step in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | {direction taken, complement bit, true bit} |
| slot_req_o | output | 1 | Request a bus slot from the slot engine |
| slot_write_o | output | 1 | 1 = write slot, 0 = read slot |
| slot_wbit_o | output | 1 | Bit to drive in a write slot |
| slot_ack_i | input | 1 | Slot engine finished the requested slot |
| slot_rbit_i | input | 1 | Sampled bus level, valid with slot_ack_i on a read slot |

## Verification
busy_o is due one cycle after an accepted start. done_o and the new status_o are due in the cycle right after the acknowledge of the last slot, and done_o must clear one cycle later. The bench's slot-engine model counts the cycles since its last acknowledge. It accepts done_o only on the first sample after that acknowledge and checks that done_o and busy_o are low one sample later. The slot engine answers with latencies of zero to two cycles, so every result is sampled relative to the acknowledge and not to a fixed cycle after start.

// File: rtl/trip_pkg.sv
package trip_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ID,
        ST_RD_CMP,
        ST_WR,
        ST_FIN
    } trip_state_e;

    // packed MSB first: bit2 = direction taken, bit1 = complement, bit0 = true bit
    typedef struct packed {
        logic dir;
        logic cmp;
        logic id;
    } trip_status_t;

    localparam int STATUS_W = $bits(trip_status_t);

    // Branch choice for one address position
    function automatic trip_status_t trip_resolve(logic id, logic cmp, logic dir_req);
        trip_status_t s;
        s.id  = id;
        s.cmp = cmp;
        if (id && cmp)        s.dir = 1'b0;     // nobody answered: abort
        else if (!id && !cmp) s.dir = dir_req;  // conflict: follow request
        else                  s.dir = id;       // single branch present
        return s;
    endfunction

endpackage

// File: rtl/trip_fsm.sv
module trip_fsm
    import trip_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic slot_ack_i,
    input  logic abort_i,
    output logic accept_o,
    output logic cap_id_o,
    output logic cap_cmp_o,
    output logic load_o,
    output logic slot_req_o,
    output logic slot_write_o,
    output logic busy_o,
    output logic done_o
);

    trip_state_e st_q, st_d;

    assign busy_o       = (st_q != ST_IDLE);
    assign done_o       = (st_q == ST_FIN);
    assign accept_o     = start_i && (st_q == ST_IDLE);
    assign slot_req_o   = (st_q == ST_RD_ID) || (st_q == ST_RD_CMP) || (st_q == ST_WR);
    assign slot_write_o = (st_q == ST_WR);
    assign cap_id_o     = (st_q == ST_RD_ID)  && slot_ack_i;
    assign cap_cmp_o    = (st_q == ST_RD_CMP) && slot_ack_i;
    assign load_o       = (cap_cmp_o && abort_i) || ((st_q == ST_WR) && slot_ack_i);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (start_i)    st_d = ST_RD_ID;
            ST_RD_ID:  if (slot_ack_i) st_d = ST_RD_CMP;
            ST_RD_CMP: if (slot_ack_i) st_d = abort_i ? ST_FIN : ST_WR;
            ST_WR:     if (slot_ack_i) st_d = ST_FIN;
            ST_FIN:                    st_d = ST_IDLE;
            default:                   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // R9: completion lasts a single cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R2: request and its kind hold until acknowledged
    a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
        (slot_req_o && !slot_ack_i) |=> (slot_req_o && $stable(slot_write_o)));

    // R10: accepted start makes the unit busy next cycle
    a_r10_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R8: start during a step does not end it
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o && start_i) |=> busy_o);

endmodule

// File: rtl/trip_decide.sv
module trip_decide
    import trip_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                accept_i,
    input  logic                dir_i,
    input  logic                cap_id_i,
    input  logic                cap_cmp_i,
    input  logic                load_i,
    input  logic                rbit_i,
    input  logic                busy_i,
    input  logic                done_i,
    input  logic                wr_slot_i,
    output logic                abort_o,
    output logic                wbit_o,
    output logic [STATUS_W-1:0] status_o
);

    logic         dir_q;
    logic         id_q;
    trip_status_t res_q, res_d, status_q;

    assign abort_o  = id_q && rbit_i;
    assign res_d    = cap_cmp_i ? trip_resolve(id_q, rbit_i, dir_q) : res_q;
    assign wbit_o   = res_q.dir;
    assign status_o = status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q    <= 1'b0;
            id_q     <= 1'b0;
            res_q    <= '0;
            status_q <= '0;
        end else begin
            if (accept_i) dir_q <= dir_i;
            if (cap_id_i) id_q  <= rbit_i;
            res_q <= res_d;
            if (load_i) status_q <= res_d;
        end
    end

    // R9: status moves only in the completion cycle
    a_r9_status_holds: assert property (@(posedge clk) disable iff (rst)
        !done_i |-> $stable(status_o));

    // R7: latched direction is frozen during a step
    a_r7_dir_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy_i && $past(busy_i)) |-> $stable(dir_q));

    // R4: no write slot after an all-ones read pair
    a_r4_no_write_on_abort: assert property (@(posedge clk) disable iff (rst)
        wr_slot_i |-> !(id_q && res_q.cmp));

    // R6: single present branch is the one written
    a_r6_follow_single: assert property (@(posedge clk) disable iff (rst)
        (wr_slot_i && (id_q != res_q.cmp)) |-> (wbit_o == id_q));

endmodule

// File: rtl/trip_search_step.sv
module trip_search_step
    import trip_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                dir_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [STATUS_W-1:0] status_o,
    output logic                slot_req_o,
    output logic                slot_write_o,
    output logic                slot_wbit_o,
    input  logic                slot_ack_i,
    input  logic                slot_rbit_i
);

    logic accept, cap_id, cap_cmp, load, abort;

    trip_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .slot_ack_i   (slot_ack_i),
        .abort_i      (abort),
        .accept_o     (accept),
        .cap_id_o     (cap_id),
        .cap_cmp_o    (cap_cmp),
        .load_o       (load),
        .slot_req_o   (slot_req_o),
        .slot_write_o (slot_write_o),
        .busy_o       (busy_o),
        .done_o       (done_o)
    );

    trip_decide u_dec (
        .clk       (clk),
        .rst       (rst),
        .accept_i  (accept),
        .dir_i     (dir_i),
        .cap_id_i  (cap_id),
        .cap_cmp_i (cap_cmp),
        .load_i    (load),
        .rbit_i    (slot_rbit_i),
        .busy_i    (busy_o),
        .done_i    (done_o),
        .wr_slot_i (slot_req_o && slot_write_o),
        .abort_o   (abort),
        .wbit_o    (slot_wbit_o),
        .status_o  (status_o)
    );

    // R1: nothing pending while idle after reset
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!slot_req_o && !done_o));

endmodule

// File: tb/trip_search_step_bench.sv
module trip_search_step_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0, dir = 1'b0, ack = 1'b0, rbit = 1'b0;
    logic       busy, done, req, wr, wbit;
    logic [2:0] status;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    trip_search_step u_trip_search_step (
        .clk(clk), .rst(rst), .start_i(start), .dir_i(dir),
        .busy_o(busy), .done_o(done), .status_o(status),
        .slot_req_o(req), .slot_write_o(wr), .slot_wbit_o(wbit),
        .slot_ack_i(ack), .slot_rbit_i(rbit)
    );

    // {dir, id, cmp, expected status[2:0], expect write slot, spare}
    localparam logic [7:0] VEC [8] = '{
        8'b0_0_0_000_1_0,
        8'b0_0_1_010_1_0,
        8'b0_1_0_101_1_0,
        8'b0_1_1_011_0_0,
        8'b1_0_0_100_1_0,
        8'b1_0_1_010_1_0,
        8'b1_1_0_101_1_0,
        8'b1_1_1_011_0_0
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_step(input logic d, input logic id, input logic cmp,
                           input bit poke, input int lat,
                           output logic [2:0] st, output int nrd, output int nwr,
                           output logic wb, output bit order_ok, output bit done_ok,
                           output logic busy_start, output logic busy_end);
        int slot;
        int since_ack;
        int guard;
        slot = 0; since_ack = 0; guard = 0;
        nrd = 0; nwr = 0; wb = 1'b0; order_ok = 1'b1;
        @(negedge clk); start = 1'b1; dir = d;
        @(negedge clk); start = 1'b0;
        busy_start = busy;
        if (poke) begin
            start = 1'b1; dir = ~d;
            @(negedge clk); start = 1'b0;
        end
        while (!done && guard < 1000) begin
            if (req) begin
                for (int k = 0; k < lat; k++) begin
                    @(negedge clk);
                    if (!req) order_ok = 1'b0;
                end
                if (wr) begin
                    nwr++; wb = wbit;
                    if (slot != 2) order_ok = 1'b0;
                end else begin
                    nrd++;
                    if (slot > 1) order_ok = 1'b0;
                end
                rbit = (slot == 0) ? id : cmp;
                ack = 1'b1;
                @(negedge clk);
                ack = 1'b0;
                slot++;
                since_ack = 0;
            end else begin
                @(negedge clk);
                since_ack++;
            end
            guard++;
        end
        st = status;
        done_ok = done && (since_ack == 0) && (slot == ((id && cmp) ? 2 : 3));
        @(negedge clk);
        busy_end = busy;
        if (done) done_ok = 1'b0;
        if (status != st) done_ok = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [2:0] st;
        int nrd, nwr;
        logic wb, bs, be;
        bit ook, dok;
        logic [2:0] held;

        repeat (3) @(negedge clk);
        // R1: values during reset
        chk(!busy && !done && !req && status == 3'b000, "R1 reset state", {busy, done, req}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !req && status == 3'b000, "R1 after reset", int'(status), 0);

        for (int i = 0; i < 8; i++) begin
            do_step(VEC[i][7], VEC[i][6], VEC[i][5], 1'b0, i % 3,
                    st, nrd, nwr, wb, ook, dok, bs, be);
            chk(st == VEC[i][4:2], "R3/R4/R5/R6 status", int'(st), int'(VEC[i][4:2]));
            chk(nrd == 2, "R2 read slots", nrd, 2);
            chk(nwr == int'(VEC[i][1]), "R4 write slot count", nwr, int'(VEC[i][1]));
            chk(ook, "R2 slot order", int'(ook), 1);
            if (VEC[i][1]) chk(wb == VEC[i][4], "R5/R6 written bit", int'(wb), int'(VEC[i][4]));
            chk(dok, "R9 done timing", int'(dok), 1);
            chk(bs && !be, "R10 busy window", {bs, be}, 2);
        end

        // R7/R8: start and direction change during a step are ignored
        do_step(1'b0, 1'b0, 1'b0, 1'b1, 1, st, nrd, nwr, wb, ook, dok, bs, be);
        chk(st == 3'b000, "R7 R8 status with poke", int'(st), 0);
        chk(wb == 1'b0 && nwr == 1, "R7 written dir latched", int'(wb), 0);
        chk(!busy && !done, "R8 no second step", {busy, done}, 0);

        // R9: status holds after done with inputs moving
        held = status;
        for (int k = 0; k < 5; k++) begin
            dir = ~dir; rbit = ~rbit;
            @(negedge clk);
        end
        chk(status == held && !done && !busy, "R9 status held", int'(status), int'(held));

        // R1: reset in the middle of a step
        do_step(1'b1, 1'b1, 1'b0, 1'b0, 0, st, nrd, nwr, wb, ook, dok, bs, be);
        @(negedge clk); start = 1'b1; dir = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy && req, "R1 step running", {busy, req}, 3);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk(!busy && !req && !done && status == 3'b000, "R1 mid-step reset", int'(status), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule